// File: doc/BRIEF.md
# Strided Vector Memory with Seventeen-Way Interleaving

This block is the memory side of a sixteen-lane SIMD engine. A single command gives an operation (load or store), a start address and a signed stride. From these the block forms one element address per lane, `start + lane*stride`. It then splits each address into a storage bank and a row inside that bank. Data moves between every lane and its bank in one step, so software never has to pack, unpack or shuffle.

Storage is divided into seventeen banks. Seventeen is prime and larger than the lane count, so any stride that is not a multiple of seventeen spreads the sixteen lanes over sixteen different banks. Those accesses finish in a single cycle and leave exactly one bank idle.

When two lanes land in the same bank, the block raises a conflict flag and falls back to one lane per cycle. This happens when the stride is a multiple of seventeen, and also when an address wraps around the top of the address space. The bank and row come from a multiply-by-reciprocal quotient with one correction step, not from a general divider.

Top module: `strided_vec_mem`

## Requirements
- R1: Lane K (0..15) accesses element address (start + K*stride) modulo 2^ADDR_W, with the stride taken as a two's complement ADDR_W-bit value; addresses past the top wrap to the bottom.
- R2: Every element address owns one distinct storage word, held in bank (address mod 17) at row (address div 17); a load returns the value last stored at that address, whatever stride either access used.
- R3: A command accepted while idle whose sixteen lane addresses fall in sixteen different banks raises `done` in the next cycle with `busy` low and `conflict` low; load data appears on `rdData` (lane K at bits K*DATA_W and up) in that same cycle.
- R4: A command accepted while idle in which any two lanes share a bank sets `conflict` and `busy` in the next cycle. It then performs one lane per cycle and raises `done` with `busy` low sixteen cycles after a conflict-free command would have, with the same load data a conflict-free access would give.
- R5: A serialized store handles lanes in ascending order, so when several lanes hit one address, the highest lane's data remains.
- R6: `cmdValid` is ignored while `busy` is high; such a command writes nothing and changes no output.
- R7: A conflict-free access enables exactly sixteen of the seventeen banks.
- R8: After reset, `done`, `busy` and `conflict` are low and `rdData` is all zeros.
- R9: `conflict` keeps the value set by the last accepted command until the next one is accepted. `rdData` changes only when a load completes; stores and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdWrite | input | 1 | 1 = store, 0 = load |
| cmdStart | input | ADDR_W | Element address of lane 0 |
| cmdStride | input | ADDR_W | Signed (two's complement) distance between lanes |
| wrData | input | 16*DATA_W | Store data, lane K at bits K*DATA_W |
| rdData | output | 16*DATA_W | Load result, lane K at bits K*DATA_W |
| done | output | 1 | One-cycle pulse when a command completes |
| busy | output | 1 | Serialized access in progress |
| conflict | output | 1 | Last accepted command had a bank collision |

## Verification
The bench builds the block with ADDR_W = 10 and DATA_W = 16. This gives a 1024-word space that the bench first fills completely and mirrors in a plain array. With so small a space, every start near the top wraps, so wrap-induced collisions that break the usual prime-stride guarantee occur naturally. The sweep runs every stride from -40 to 40 from several starts, which includes 0, ±17 and ±34. Stores over a range of strides are each read back with a different stride, which tests the bank/row split against the linear model.

// File: rtl/svm_pkg.sv
package svm_pkg;
  parameter int NUM_LANES = 16;
  parameter int NUM_BANKS = 17;
  parameter int LANE_W    = $clog2(NUM_LANES);
  parameter int BANK_W    = $clog2(NUM_BANKS);

  typedef struct packed {
    logic                 latch;      // capture the command for serial replay
    logic                 useLatched; // address source is the captured command
    logic                 access;     // banks are touched this cycle
    logic [NUM_LANES-1:0] laneMask;   // lanes taking part this cycle
  } svm_ctrl_t;
endpackage

// File: rtl/svm_divmod.sv
module svm_divmod #(
  parameter int ADDR_W = 10,
  parameter int DIV    = 17
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic [ADDR_W-1:0]       quo,
  output logic [$clog2(DIV)-1:0]  rem
);
  localparam int SHIFT = ADDR_W + 5;
  localparam int PW    = ADDR_W + SHIFT;
  localparam int RW    = $clog2(DIV);
  localparam int EW    = ADDR_W + 6;
  localparam logic [SHIFT-1:0] MULT = SHIFT'((2 ** SHIFT) / DIV);

  logic [PW-1:0]     prod;
  logic [ADDR_W-1:0] qEst;
  logic [EW-1:0]     back;
  logic [EW-1:0]     rEst;

  always_comb begin
    prod = PW'(addr) * PW'(MULT);
    qEst = prod[PW-1:SHIFT];
    back = EW'(qEst) * EW'(DIV);
    rEst = EW'(addr) - back;
    if (rEst >= EW'(DIV)) begin
      quo = qEst + 1'b1;
      rem = RW'(rEst - EW'(DIV));
    end else begin
      quo = qEst;
      rem = RW'(rEst);
    end
  end

  always_comb begin
    AST_REM_BOUND: assert (rem < RW'(DIV)); // R2
  end
endmodule

// File: rtl/svm_bank.sv
module svm_bank #(
  parameter int ROWS   = 61,
  parameter int DATA_W = 16,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en && we) mem[row] <= wd;
  end

  assign rd = mem[row];
endmodule

// File: rtl/svm_datapath.sv
module svm_datapath
  import svm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  svm_ctrl_t                     ctrl,
  input  logic                          cmdWrite,
  input  logic [ADDR_W-1:0]             cmdStart,
  input  logic [ADDR_W-1:0]             cmdStride,
  input  logic [NUM_LANES*DATA_W-1:0]   wrData,
  output logic [NUM_LANES*DATA_W-1:0]   rdData,
  output logic                          conflictNow
);
  localparam int ROWS  = ((2 ** ADDR_W) + NUM_BANKS - 1) / NUM_BANKS;
  localparam int ROW_W = $clog2(ROWS);
  localparam int CNT_W = $clog2(NUM_LANES + 1);

  logic [ADDR_W-1:0] latStart, latStride;
  logic              latWrite;
  logic [DATA_W-1:0] latData [NUM_LANES];

  logic [ADDR_W-1:0] effStart, effStride;
  logic              effWrite;
  logic [DATA_W-1:0] laneWd   [NUM_LANES];
  logic [ADDR_W-1:0] laneAddr [NUM_LANES];
  logic [ADDR_W-1:0] laneQuo  [NUM_LANES];
  logic [BANK_W-1:0] laneBank [NUM_LANES];
  logic [ROW_W-1:0]  laneRow  [NUM_LANES];
  logic [DATA_W-1:0] laneRd   [NUM_LANES];
  logic [DATA_W-1:0] rdQ      [NUM_LANES];

  logic [NUM_BANKS-1:0] bankEn;
  logic [LANE_W-1:0]    bankLane [NUM_BANKS];
  logic [ROW_W-1:0]     bankRow  [NUM_BANKS];
  logic [DATA_W-1:0]    bankWd   [NUM_BANKS];
  logic [DATA_W-1:0]    bankRd   [NUM_BANKS];
  logic [CNT_W-1:0]     hitCnt   [NUM_BANKS];

  assign effStart  = ctrl.useLatched ? latStart  : cmdStart;
  assign effStride = ctrl.useLatched ? latStride : cmdStride;
  assign effWrite  = ctrl.useLatched ? latWrite  : cmdWrite;

  // command capture for serial replay
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latStart  <= '0;
      latStride <= '0;
      latWrite  <= 1'b0;
    end else if (ctrl.latch) begin
      latStart  <= cmdStart;
      latStride <= cmdStride;
      latWrite  <= cmdWrite;
    end
  end

  // per-lane address generation and split
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    assign laneWd[k]   = ctrl.useLatched ? latData[k] : wrData[k*DATA_W +: DATA_W];
    assign laneAddr[k] = effStart + effStride * ADDR_W'(k);

    svm_divmod #(.ADDR_W(ADDR_W), .DIV(NUM_BANKS)) u_split (
      .addr (laneAddr[k]),
      .quo  (laneQuo[k]),
      .rem  (laneBank[k])
    );
    assign laneRow[k] = ROW_W'(laneQuo[k]);
    assign laneRd[k]  = bankRd[laneBank[k]];
    assign rdData[k*DATA_W +: DATA_W] = rdQ[k];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        latData[k] <= '0;
        rdQ[k]     <= '0;
      end else begin
        if (ctrl.latch) latData[k] <= wrData[k*DATA_W +: DATA_W];
        if (ctrl.access && !effWrite && ctrl.laneMask[k]) rdQ[k] <= laneRd[k];
      end
    end
  end

  // collision detection over all lanes of the incoming command
  always_comb begin
    conflictNow = 1'b0;
    for (int r = 0; r < NUM_BANKS; r++) begin
      hitCnt[r] = '0;
      for (int k = 0; k < NUM_LANES; k++) begin
        if (laneBank[k] == BANK_W'(r)) hitCnt[r] = hitCnt[r] + CNT_W'(1);
      end
      if (hitCnt[r] > CNT_W'(1)) conflictNow = 1'b1;
    end
  end

  // bank-to-lane rearrangement; lowest active lane wins a bank
  always_comb begin
    for (int r = 0; r < NUM_BANKS; r++) begin
      bankEn[r]   = 1'b0;
      bankLane[r] = '0;
      for (int k = NUM_LANES - 1; k >= 0; k--) begin
        if (ctrl.laneMask[k] && laneBank[k] == BANK_W'(r)) begin
          bankEn[r]   = 1'b1;
          bankLane[r] = LANE_W'(k);
        end
      end
    end
  end

  for (genvar r = 0; r < NUM_BANKS; r++) begin : g_bank
    assign bankRow[r] = laneRow[bankLane[r]];
    assign bankWd[r]  = laneWd[bankLane[r]];

    svm_bank #(.ROWS(ROWS), .DATA_W(DATA_W)) u_bank (
      .clk (clk),
      .en  (ctrl.access && bankEn[r]),
      .we  (effWrite),
      .row (bankRow[r]),
      .wd  (bankWd[r]),
      .rd  (bankRd[r])
    );
  end

  AST_FAST_BANK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.access && !ctrl.useLatched) |-> ($countones(bankEn) == NUM_LANES)); // R7

  AST_SERIAL_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.access && ctrl.useLatched) |-> ($countones(bankEn) == 1)); // R4
endmodule

// File: rtl/svm_control.sv
module svm_control
  import svm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmdValid,
  input  logic      conflictNow,
  output svm_ctrl_t ctrl,
  output logic      done,
  output logic      busy,
  output logic      conflict
);
  typedef enum logic {ST_IDLE, ST_SERIAL} state_t;

  state_t            state;
  logic [LANE_W-1:0] step;
  logic              accept;

  assign accept = cmdValid && (state == ST_IDLE);
  assign busy   = (state == ST_SERIAL);

  always_comb begin
    ctrl.latch      = accept && conflictNow;
    ctrl.useLatched = busy;
    ctrl.access     = (accept && !conflictNow) || busy;
    if (busy)        ctrl.laneMask = NUM_LANES'(1) << step;
    else if (accept) ctrl.laneMask = '1;
    else             ctrl.laneMask = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step     <= '0;
      done     <= 1'b0;
      conflict <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        conflict <= conflictNow;
        if (conflictNow) begin
          state <= ST_SERIAL;
          step  <= '0;
        end else begin
          done <= 1'b1;
        end
      end else if (busy) begin
        step <= step + 1'b1;
        if (step == LANE_W'(NUM_LANES - 1)) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  AST_FAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !busy && !conflictNow) |=> (done && !busy)); // R3

  AST_SERIAL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !busy && conflictNow) |=> (busy && !done && conflict)); // R4

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(conflict)); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
endmodule

// File: rtl/strided_vec_mem.sv
module strided_vec_mem
  import svm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmdValid,
  input  logic                        cmdWrite,
  input  logic [ADDR_W-1:0]           cmdStart,
  input  logic [ADDR_W-1:0]           cmdStride,
  input  logic [NUM_LANES*DATA_W-1:0] wrData,
  output logic [NUM_LANES*DATA_W-1:0] rdData,
  output logic                        done,
  output logic                        busy,
  output logic                        conflict
);
  svm_ctrl_t ctrl;
  logic      conflictNow;

  svm_control u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmdValid    (cmdValid),
    .conflictNow (conflictNow),
    .ctrl        (ctrl),
    .done        (done),
    .busy        (busy),
    .conflict    (conflict)
  );

  svm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .cmdWrite    (cmdWrite),
    .cmdStart    (cmdStart),
    .cmdStride   (cmdStride),
    .wrData      (wrData),
    .rdData      (rdData),
    .conflictNow (conflictNow)
  );
endmodule

// File: tb/strided_vec_mem_tb.sv
module strided_vec_mem_tb;
  localparam int LANES  = 16;
  localparam int BANKS  = 17;
  localparam int ADDR_W = 10;
  localparam int DW     = 16;
  localparam int MEM    = 1 << ADDR_W;
  localparam int VW     = LANES * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [ADDR_W-1:0] cmdStart = '0, cmdStride = '0;
  logic [VW-1:0] wrData = '0;
  logic [VW-1:0] rdData;
  logic done, busy, conflict;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] model [MEM];

  always #4 clk = ~clk; // 125 MHz

  strided_vec_mem #(.ADDR_W(ADDR_W), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdStart(cmdStart), .cmdStride(cmdStride), .wrData(wrData),
    .rdData(rdData), .done(done), .busy(busy), .conflict(conflict)
  );

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int laneAddr(int start, int stride, int k);
    return (start + k * stride) & (MEM - 1);
  endfunction

  function automatic bit hasConflict(int start, int stride);
    for (int a = 0; a < LANES; a++)
      for (int b = a + 1; b < LANES; b++)
        if (laneAddr(start, stride, a) % BANKS == laneAddr(start, stride, b) % BANKS) return 1;
    return 0;
  endfunction

  function automatic logic [VW-1:0] expLoad(int start, int stride);
    logic [VW-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*DW +: DW] = model[laneAddr(start, stride, k)];
    return v;
  endfunction

  function automatic logic [VW-1:0] pattern(int seed);
    logic [VW-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*DW +: DW] = DW'(seed * 37 + k * 1031 + 5);
    return v;
  endfunction

  task automatic drive(input bit wr, input int start, input int stride, input int seed);
    cmdValid  = 1'b1;
    cmdWrite  = wr;
    cmdStart  = ADDR_W'(start);
    cmdStride = ADDR_W'(stride);
    wrData    = pattern(seed);
  endtask

  // one command; returns at the negedge where done is expected
  task automatic doCmd(input bit wr, input int start, input int stride, input int seed);
    bit expConf;
    logic [VW-1:0] prevRd, wd;
    expConf = hasConflict(start, stride);
    prevRd  = rdData;
    wd      = pattern(seed);
    @(negedge clk);
    drive(wr, start, stride, seed);
    @(negedge clk);
    cmdValid = 1'b0;
    if (!expConf) begin
      chk(done && !busy && !conflict, "R3/R7 fast timing", {done, busy, conflict}, 3'b100);
    end else begin
      chk(busy && !done && conflict, "R4 serial start", {done, busy, conflict}, 3'b011);
      repeat (LANES) @(negedge clk);
      chk(done && !busy, "R4 serial done", {done, busy}, 2'b10);
    end
    if (wr) begin
      for (int k = 0; k < LANES; k++) model[laneAddr(start, stride, k)] = wd[k*DW +: DW];
      chk(rdData == prevRd, "R9 store keeps rdData", rdData, prevRd);
    end else begin
      chk(rdData == expLoad(start, stride), "R1/R2 load data", rdData, expLoad(start, stride));
    end
  endtask

  initial begin
    logic [VW-1:0] hold;
    for (int i = 0; i < MEM; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !conflict && rdData == '0, "R8 reset", {done, busy, conflict}, '0);

    // fill the whole space, stride 1
    for (int i = 0; i < MEM / LANES; i++) doCmd(1, i * LANES, 1, 1000 + i);

    // load sweep over strides and starts, including wrap at the top
    for (int s = -40; s <= 40; s++) begin
      doCmd(0, 0, s, 0);
      doCmd(0, 500, s, 0);
      doCmd(0, 1015, s, 0);
    end

    // strided stores read back by a different stride
    for (int s = -20; s <= 20; s++) begin
      doCmd(1, 200 + 3 * s, s, 2000 + s);
      doCmd(0, 200 + 3 * s, s, 0);
      doCmd(0, 140, 1, 0);
      doCmd(0, 1000, 3, 0);
    end

    // R5: stride 0 store, every lane on one address; highest lane remains
    doCmd(1, 333, 0, 77);
    doCmd(0, 333, 1, 0);
    chk(rdData[DW-1:0] == pattern(77)[(LANES-1)*DW +: DW], "R5 last lane wins",
        rdData[DW-1:0], pattern(77)[(LANES-1)*DW +: DW]);

    // R6 and R9: command offered while busy is ignored; flags hold
    @(negedge clk);
    drive(0, 50, 17, 0);
    @(negedge clk);
    chk(busy && conflict, "R4 stride 17 conflict", {busy, conflict}, 2'b11);
    drive(1, 900, 1, 9999);
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (LANES - 1) @(negedge clk);
    chk(done && !busy, "R4 stride 17 done", {done, busy}, 2'b10);
    chk(rdData == expLoad(50, 17), "R4 serialized load data", rdData, expLoad(50, 17));
    hold = rdData;
    repeat (3) @(negedge clk);
    chk(conflict && rdData == hold, "R9 conflict and data held", {conflict, rdData}, {1'b1, hold});
    doCmd(0, 900, 1, 0);
    chk(rdData == expLoad(900, 1), "R6 busy command ignored", rdData, expLoad(900, 1));
    chk(!conflict, "R9 flag cleared by next command", conflict, 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule